// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects interrupt lines from peripherals into groups of 32 sources, called banks, and presents one summary interrupt line per bank to the processor. Software reaches each bank through a small window of 32-bit registers on a simple strobed bus. The registers hold the live status, the enable mask, a write-one-to-set port, a write-one-to-clear port, and two per-source mode registers: polarity and edge select.

Each source passes through a two-flop synchronizer. A pair of mode bits then chooses how the source is treated. In the two level modes the status bit tracks the synchronized input, with optional inversion. In the two edge modes a rising or a falling transition is latched, and the latched bit holds until software clears it. For each bank, a lowest-bit encoder reports the index of the first pending enabled source, so that the handler can find its source without scanning.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Bank b occupies bytes b*0x18 to b*0x18+0x17, and source i sits in bank i>>5 at bit i&31. The offsets inside a bank are: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10, edge 0x14. A read returns its data on rdata one clock after rd_en, and the set and clear offsets read as zero.
- R2: After reset, every enable bit is 0 and every polarity bit is 1. Edge bits 13, 14 and 15 of bank 0 are 1 (value 0x0000E000), all other edge bits are 0, no status bit is set, and every irq output is low.
- R3: The mode pair {polarity, edge} = {1,0} gives an active-high level source, and {0,0} gives an active-low level source. A level source's status bit follows its input two clocks after the input changes.
- R4: The mode pair {1,1} latches a rising transition and {0,1} latches a falling transition. The opposite transition is ignored. The status bit rises three clocks after the qualifying input change and stays set after the input returns.
- R5: Writing 1 to a bit of the clear register clears that source's latched bit, and writing 0 leaves it unchanged. Clearing a level source whose input is still active leaves its status bit set.
- R6: Writing 1 to a bit of the set register forces that source's status bit on, and writing 0 leaves it unchanged. Writes to the status offset have no effect.
- R7: irq[b] is high exactly when some bit of bank b's status AND enable is set. Clearing an enable bit removes that source from irq without changing its status bit.
- R8: pend_vld[b] equals irq[b]. pend_idx[b*5 +: 5] gives the lowest-numbered bit of bank b's status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_BANKS*32 | Raw interrupt sources, source i at bit i |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| irq | output | NUM_BANKS | Summary interrupt, one per bank |
| pend_idx | output | NUM_BANKS*5 | Lowest pending enabled source per bank |
| pend_vld | output | NUM_BANKS | pend_idx of that bank is meaningful |

## Verification
The bench counts clocks between an input change and irq, so a design that skips a synchronizer stage or adds one shows up as early or late by one cycle. It applies the transition opposite to the selected edge and expects no latch; a detector that ignores polarity would latch it. It clears a level source while the input is still active and expects the status bit to stay set, which a design that stores level status in the latch would get wrong. It also sets two bits and removes the lower one from the enable mask, so an encoder that looks at status without the mask would report the wrong index.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W = 8,
  parameter logic [31:0] BANK0_EDGE_RST = 32'h0000_E000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BANKS*32-1:0] src_in,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NUM_BANKS-1:0]   irq,
  output logic [NUM_BANKS*5-1:0] pend_idx,
  output logic [NUM_BANKS-1:0]   pend_vld
);
  localparam int STRIDE = 24;
  localparam int IDX_W = 5;

  logic [NUM_BANKS*32-1:0] rd_flat;
  logic [31:0] rd_mux;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = b * STRIDE;
    localparam logic [31:0] EDGE_RST = (b == 0) ? BANK0_EDGE_RST : 32'h0;

    logic        hit;
    logic [ADDR_W-1:0] off;
    logic [31:0] en_q, pol_q, edg_q, lat_q, s1_q, s2_q, s3_q;
    logic [31:0] evt, status, pend;
    logic        wr_set, wr_clr;
    logic [IDX_W-1:0] idx;

    assign hit = (int'(addr) >= BASE) && (int'(addr) < BASE + STRIDE);
    assign off = addr - ADDR_W'(BASE);
    assign wr_set = wr_en && hit && (off == ADDR_W'(8'h08));
    assign wr_clr = wr_en && hit && (off == ADDR_W'(8'h0C));

    assign evt = (pol_q & s2_q & ~s3_q) | (~pol_q & ~s2_q & s3_q);
    assign status = lat_q | (~edg_q & ~(s2_q ^ pol_q));
    assign pend = status & en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= '0;
        s2_q <= '0;
        s3_q <= '0;
      end else begin
        s1_q <= src_in[b*32 +: 32];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= '0;
        pol_q <= '1;
        edg_q <= EDGE_RST;
        lat_q <= '0;
      end else begin
        lat_q <= (lat_q & ~(wr_clr ? wdata : 32'h0)) | (wr_set ? wdata : 32'h0) | (evt & edg_q);
        if (wr_en && hit) begin
          case (off)
            ADDR_W'(8'h04): en_q  <= wdata;
            ADDR_W'(8'h10): pol_q <= wdata;
            ADDR_W'(8'h14): edg_q <= wdata;
            default: ;
          endcase
        end
      end
    end

    always_comb begin
      idx = '0;
      for (int i = 31; i >= 0; i--)
        if (pend[i]) idx = IDX_W'(i);
    end

    assign irq[b] = |pend;
    assign pend_vld[b] = pend != 32'h0;
    assign pend_idx[b*IDX_W +: IDX_W] = idx;

    always_comb begin
      rd_flat[b*32 +: 32] = '0;
      if (hit) begin
        case (off)
          ADDR_W'(8'h00): rd_flat[b*32 +: 32] = status;
          ADDR_W'(8'h04): rd_flat[b*32 +: 32] = en_q;
          ADDR_W'(8'h10): rd_flat[b*32 +: 32] = pol_q;
          ADDR_W'(8'h14): rd_flat[b*32 +: 32] = edg_q;
          default: ;
        endcase
      end
    end

    assert_set_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((status & $past(wdata)) == $past(wdata)));
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((lat_q & $past(wdata) & ~$past(evt & edg_q)) == 32'h0));
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 32'h0) |-> !irq[b]);
    assert_idx_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld[b] |-> (pend[idx] && ((pend & ((32'd1 << idx) - 32'd1)) == 32'h0)));
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_BANKS; k++) rd_mux = rd_mux | rd_flat[k*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : 32'h0;
  end
endmodule

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;
  localparam int NB = 5;
  localparam int AW = 8;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*32-1:0] src_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NB-1:0] irq, pend_vld;
  logic [NB*5-1:0] pend_idx;

  int total = 0;
  int bad = 0;

  always #(TCK/2) clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .pend_idx(pend_idx), .pend_vld(pend_vld));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int b = 0; b < NB; b++) begin
      rd(b*24 + 4, v);  check("R2 enable", v, 32'h0);
      rd(b*24 + 16, v); check("R2 polarity", v, 32'hFFFF_FFFF);
      rd(b*24 + 20, v); check("R2 edge", v, (b == 0) ? 32'h0000_E000 : 32'h0);
      rd(b*24, v);      check("R2 status", v, 32'h0);
    end
    check("R2 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(24 + 4, 32'h18);
    @(negedge clk); src_in[35] = 1'b1;
    clocks(1); check("R3 level high one clock", 32'(irq[1]), 32'h0);
    clocks(1); check("R3 level high two clocks", 32'(irq[1]), 32'h1);
    check("R8 index level", 32'(pend_idx[5 +: 5]), 32'd3);
    rd(24, v); check("R1 status bank1", v, 32'h8);
    wr(24 + 12, 32'h8);
    rd(24, v); check("R5 level survives clear", v, 32'h8);
    @(negedge clk); src_in[35] = 1'b0;
    clocks(2); check("R3 level drop", 32'(irq[1]), 32'h0);
    wr(24 + 16, 32'hFFFF_FFEF);
    check("R3 level low active", 32'(irq[1]), 32'h1);
    check("R8 index low", 32'(pend_idx[5 +: 5]), 32'd4);
    wr(24 + 16, 32'hFFFF_FFFF);
    check("R3 level low restored", 32'(irq[1]), 32'h0);
  endtask

  task automatic t_rise;
    wr(4, 32'h0000_2000);
    @(negedge clk); src_in[13] = 1'b1;
    clocks(2); check("R4 rise two clocks", 32'(irq[0]), 32'h0);
    clocks(1); check("R4 rise three clocks", 32'(irq[0]), 32'h1);
    check("R8 index rise", 32'(pend_idx[0 +: 5]), 32'd13);
    @(negedge clk); src_in[13] = 1'b0;
    clocks(5); check("R4 held after return", 32'(irq[0]), 32'h1);
    wr(12, 32'h0);
    check("R5 zero clear no effect", 32'(irq[0]), 32'h1);
    wr(12, 32'h0000_2000);
    check("R5 clear drops", 32'(irq[0]), 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    wr(48 + 20, 32'h80);
    wr(48 + 16, 32'hFFFF_FF7F);
    wr(48 + 4, 32'h80);
    @(negedge clk); src_in[71] = 1'b1;
    clocks(4); check("R4 fall ignores rise", 32'(irq[2]), 32'h0);
    @(negedge clk); src_in[71] = 1'b0;
    clocks(2); check("R4 fall two clocks", 32'(irq[2]), 32'h0);
    clocks(1); check("R4 fall latched", 32'(irq[2]), 32'h1);
    check("R8 index fall", 32'(pend_idx[10 +: 5]), 32'd7);
    rd(48, v); check("R4 fall status", v, 32'h80);
    wr(48 + 12, 32'h80);
    check("R5 fall cleared", 32'(irq[2]), 32'h0);
  endtask

  task automatic t_set;
    logic [31:0] v;
    wr(72, 32'hFFFF_FFFF);
    rd(72, v); check("R6 status write ignored", v, 32'h0);
    wr(72 + 8, 32'h0010_0000);
    rd(72, v); check("R6 set forces", v, 32'h0010_0000);
    check("R7 disabled no irq", 32'(irq[3]), 32'h0);
    wr(72 + 8, 32'h0);
    rd(72, v); check("R6 zero set no effect", v, 32'h0010_0000);
    rd(72 + 8, v); check("R1 set reads zero", v, 32'h0);
    rd(72 + 12, v); check("R1 clear reads zero", v, 32'h0);
    wr(72 + 4, 32'h0010_0000);
    check("R7 enabled irq", 32'(irq[3]), 32'h1);
    check("R8 index set", 32'(pend_idx[15 +: 5]), 32'd20);
    wr(72 + 12, 32'h0010_0000);
    check("R5 set bit cleared", 32'(irq[3]), 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(96 + 8, 32'h204);
    wr(96 + 4, 32'h204);
    check("R8 lowest of two", 32'(pend_idx[20 +: 5]), 32'd2);
    check("R8 valid", 32'(pend_vld[4]), 32'h1);
    wr(96 + 4, 32'h200);
    check("R8 masked lower bit", 32'(pend_idx[20 +: 5]), 32'd9);
    rd(96, v); check("R7 status kept", v, 32'h204);
    wr(96 + 4, 32'h0);
    check("R7 all disabled", 32'(irq[4]), 32'h0);
    check("R8 valid low", 32'(pend_vld[4]), 32'h0);
    check("R7 other banks quiet", 32'(irq), 32'h0);
  endtask

  initial begin
    #(TCK * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clocks(3);
    rst_n = 1'b1;
    clocks(1);
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_set();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule